// File: doc/BRIEF.md
# Half-Word Staging Register Bridge

This bridge connects a host bus that carries 16 bits per access to a register file whose entries are 32 bits wide. A single staging register makes up the difference. To write a 32-bit register, the host first writes the upper half-word to the stage address. It then writes the lower half-word to the target address, and the bridge commits the joined 32-bit word in one back-end write. To read a 32-bit register, the host reads the target address and receives the upper half-word in that access. The bridge parks the lower half-word in the stage, and a later read of the stage address returns it.

Each host address falls into one of four classes: the stage itself, a wide (32-bit) register, a native 16-bit register, or a data channel (pixel, code or attribute stream). Native registers and data channels bypass the stage completely. They are written zero-extended and read from the low half of the back-end word.

A small controller sequences every access. Its states are:

- IDLE: the host may issue a request.
- WRITE: one back-end write strobe.
- READ: one back-end read strobe.
- WAIT: the back-end data is captured.
- REPLY: read data is presented to the host.

The transitions are:

- IDLE→WRITE on a write to a non-stage address.
- IDLE stays in IDLE on a write to the stage.
- IDLE→READ on a read of a non-stage address.
- IDLE→REPLY on a read of the stage.
- WRITE→IDLE.
- READ→WAIT.
- WAIT→REPLY.
- REPLY→IDLE.

The back end answers a read strobe with data in the following cycle.

Top module: `hsb_top`

## Requirements
- R1: After reset the stage holds zero, `host_ready` is 1, and neither `reg_wr` nor `reg_rd` is asserted.
- R2: A host write to the stage address (0x00) loads `host_wdata` into the stage and causes no back-end access.
- R3: A host write to a wide address (0x40–0x7F) produces exactly one back-end write of {stage, `host_wdata`} to that address. The stage is placed in bits 31:16.
- R4: A host read of a wide address returns bits 31:16 of the register. `host_rvalid` rises three cycles after the request edge.
- R5: A wide read loads bits 15:0 of the register into the stage, replacing any staged upper half. The next stage read returns them.
- R6: A stage read returns the stage value one cycle after the request edge. It causes no back-end access and leaves the stage unchanged.
- R7: A write to a native 16-bit address (any address outside the stage, wide and channel ranges) writes {16'h0000, `host_wdata`} to the back end and leaves the stage unchanged.
- R8: A read of a native address returns bits 15:0 of the register and leaves the stage unchanged.
- R9: Data channel addresses (0xF0 pixel, 0xF1 code, 0xF2 attribute) behave like native addresses. They are written zero-extended, read from the low half, and never touch the stage.
- R10: `host_ready` is 0 from the edge that accepts a back-end access until the access completes. Host strobes presented while it is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | HALF_W | Host write half-word |
| host_ready | output | 1 | Bridge can accept a strobe |
| host_rvalid | output | 1 | Read data valid, one cycle |
| host_rdata | output | HALF_W | Read half-word |
| reg_wr | output | 1 | Back-end write strobe |
| reg_rd | output | 1 | Back-end read strobe |
| reg_addr | output | ADDR_W | Back-end address |
| reg_wdata | output | 2*HALF_W | Back-end write word |
| reg_rdata | input | 2*HALF_W | Back-end read word, valid the cycle after `reg_rd` |

## Verification
The main function is exercised with three orderings of stage and wide accesses:
- An upper-then-lower write pair shows that the staged half-word lands in bits 31:16.
- A stage write followed by a wide read, then a stage read, separates "read overwrites the stage" from "read leaves a pending upper half".
- A stage write followed by native and channel traffic, then a later wide write, shows that bypass accesses neither consume nor disturb the staged value.

Back-end strobes are counted around each stage access, and a strobe issued while the bridge is busy is followed by a check that no extra write reached the register file.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
    typedef enum logic [1:0] {
        CLS_STAGE,
        CLS_WIDE,
        CLS_NATIVE,
        CLS_CHAN
    } addr_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_WAIT,
        ST_REPLY
    } ctrl_st_e;
endpackage

// File: rtl/hsb_decode.sv
module hsb_decode
    import hsb_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int STAGE_ADDR = 'h00,
    parameter int WIDE_LO    = 'h40,
    parameter int WIDE_HI    = 'h7F,
    parameter int CHAN_BASE  = 'hF0,
    parameter int CHAN_COUNT = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_cls_e         cls
);
    logic [CHAN_COUNT-1:0] chan_hit;

    for (genvar i = 0; i < CHAN_COUNT; i++) begin : g_chan
        assign chan_hit[i] = (addr == ADDR_W'(CHAN_BASE + i));
    end

    always_comb begin
        if (addr == ADDR_W'(STAGE_ADDR))
            cls = CLS_STAGE;
        else if (addr >= ADDR_W'(WIDE_LO) && addr <= ADDR_W'(WIDE_HI))
            cls = CLS_WIDE;
        else if (|chan_hit)
            cls = CLS_CHAN;
        else
            cls = CLS_NATIVE;
    end
endmodule

// File: rtl/hsb_stage.sv
module hsb_stage #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HALF_W-1:0] din,
    output logic [HALF_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= din;
    end
endmodule

// File: rtl/hsb_ctrl.sv
module hsb_ctrl
    import hsb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [HALF_W-1:0]   host_wdata,
    input  addr_cls_e           host_cls,
    input  logic [HALF_W-1:0]   stage_q,
    output logic                host_ready,
    output logic                host_rvalid,
    output logic [HALF_W-1:0]   host_rdata,
    output logic                reg_wr,
    output logic                reg_rd,
    output logic [ADDR_W-1:0]   reg_addr,
    output logic [2*HALF_W-1:0] reg_wdata,
    input  logic [2*HALF_W-1:0] reg_rdata,
    output logic                stage_load,
    output logic [HALF_W-1:0]   stage_din
);
    localparam int FULL_W = 2 * HALF_W;

    ctrl_st_e            state;
    addr_cls_e           cls_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [FULL_W-1:0]   wdata_q;
    logic [HALF_W-1:0]   rdata_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (host_wr)
                        state <= (host_cls == CLS_STAGE) ? ST_IDLE : ST_WRITE;
                    else if (host_rd)
                        state <= (host_cls == CLS_STAGE) ? ST_REPLY : ST_READ;
                end
                ST_WRITE: state <= ST_IDLE;
                ST_READ:  state <= ST_WAIT;
                ST_WAIT:  state <= ST_REPLY;
                ST_REPLY: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Request and reply holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q   <= CLS_NATIVE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (state == ST_IDLE && (host_wr || host_rd)) begin
                cls_q   <= host_cls;
                addr_q  <= host_addr;
                wdata_q <= (host_cls == CLS_WIDE) ? {stage_q, host_wdata}
                                                  : {{HALF_W{1'b0}}, host_wdata};
                if (!host_wr && host_cls == CLS_STAGE)
                    rdata_q <= stage_q;
            end
            if (state == ST_WAIT)
                rdata_q <= (cls_q == CLS_WIDE) ? reg_rdata[FULL_W-1:HALF_W]
                                               : reg_rdata[HALF_W-1:0];
        end
    end

    // Outputs
    always_comb begin
        host_ready  = 1'b0;
        host_rvalid = 1'b0;
        reg_wr      = 1'b0;
        reg_rd      = 1'b0;
        stage_load  = 1'b0;
        stage_din   = host_wdata;
        unique case (state)
            ST_IDLE: begin
                host_ready = 1'b1;
                stage_load = host_wr && (host_cls == CLS_STAGE);
            end
            ST_WRITE: reg_wr = 1'b1;
            ST_READ:  reg_rd = 1'b1;
            ST_WAIT: begin
                stage_load = (cls_q == CLS_WIDE);
                stage_din  = reg_rdata[HALF_W-1:0];
            end
            ST_REPLY: host_rvalid = 1'b1;
            default: ;
        endcase
    end

    assign reg_addr   = addr_q;
    assign reg_wdata  = wdata_q;
    assign host_rdata = rdata_q;
endmodule

// File: rtl/hsb_top.sv
module hsb_top
    import hsb_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int HALF_W     = 16,
    parameter int STAGE_ADDR = 'h00,
    parameter int WIDE_LO    = 'h40,
    parameter int WIDE_HI    = 'h7F,
    parameter int CHAN_BASE  = 'hF0,
    parameter int CHAN_COUNT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [HALF_W-1:0]   host_wdata,
    output logic                host_ready,
    output logic                host_rvalid,
    output logic [HALF_W-1:0]   host_rdata,
    output logic                reg_wr,
    output logic                reg_rd,
    output logic [ADDR_W-1:0]   reg_addr,
    output logic [2*HALF_W-1:0] reg_wdata,
    input  logic [2*HALF_W-1:0] reg_rdata
);
    addr_cls_e         host_cls;
    logic              stage_load;
    logic [HALF_W-1:0] stage_din;
    logic [HALF_W-1:0] stage_q;

    hsb_decode #(
        .ADDR_W    (ADDR_W),
        .STAGE_ADDR(STAGE_ADDR),
        .WIDE_LO   (WIDE_LO),
        .WIDE_HI   (WIDE_HI),
        .CHAN_BASE (CHAN_BASE),
        .CHAN_COUNT(CHAN_COUNT)
    ) u_decode (
        .addr(host_addr),
        .cls (host_cls)
    );

    hsb_stage #(.HALF_W(HALF_W)) u_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .load (stage_load),
        .din  (stage_din),
        .q    (stage_q)
    );

    hsb_ctrl #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_cls   (host_cls),
        .stage_q    (stage_q),
        .host_ready (host_ready),
        .host_rvalid(host_rvalid),
        .host_rdata (host_rdata),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .stage_load (stage_load),
        .stage_din  (stage_din)
    );
endmodule

// File: rtl/hsb_checker.sv
module hsb_checker #(
    parameter int ADDR_W     = 8,
    parameter int HALF_W     = 16,
    parameter int STAGE_ADDR = 'h00,
    parameter int WIDE_LO    = 'h40,
    parameter int WIDE_HI    = 'h7F
) (
    input logic                clk,
    input logic                rst_n,
    input logic                host_wr,
    input logic                host_rd,
    input logic [ADDR_W-1:0]   host_addr,
    input logic [HALF_W-1:0]   host_wdata,
    input logic                host_ready,
    input logic                host_rvalid,
    input logic                reg_wr,
    input logic                reg_rd,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [2*HALF_W-1:0] reg_wdata,
    input logic [HALF_W-1:0]   stage_q
);
    logic is_stage, is_wide, wr_go, rd_go;
    assign is_stage = (host_addr == ADDR_W'(STAGE_ADDR));
    assign is_wide  = (host_addr >= ADDR_W'(WIDE_LO)) && (host_addr <= ADDR_W'(WIDE_HI));
    assign wr_go    = host_wr && host_ready;
    assign rd_go    = !host_wr && host_rd && host_ready;

    AST_STAGE_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go && is_stage |=> !reg_wr && !reg_rd && stage_q == $past(host_wdata)); // R2
    AST_WIDE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go && is_wide |=> reg_wr && reg_addr == $past(host_addr)
                             && reg_wdata == {$past(stage_q), $past(host_wdata)}); // R3
    AST_BYPASS_KEEPS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go && !is_stage && !is_wide |=> $stable(stage_q)); // R7
    AST_STAGE_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go && is_stage |=> host_rvalid && !reg_rd && $stable(stage_q)); // R6
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd || host_rvalid) |-> !host_ready); // R10
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr); // R3
    AST_REPLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid); // R4
endmodule

bind hsb_top hsb_checker #(
    .ADDR_W    (ADDR_W),
    .HALF_W    (HALF_W),
    .STAGE_ADDR(STAGE_ADDR),
    .WIDE_LO   (WIDE_LO),
    .WIDE_HI   (WIDE_HI)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_ready (host_ready),
    .host_rvalid(host_rvalid),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .stage_q    (stage_q)
);

// File: tb/sim_hsb_top.sv
module sim_hsb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int HW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [HW-1:0] host_wdata = '0;
    logic          host_ready, host_rvalid;
    logic [HW-1:0] host_rdata;
    logic          reg_wr, reg_rd;
    logic [AW-1:0] reg_addr;
    logic [2*HW-1:0] reg_wdata;
    logic [2*HW-1:0] reg_rdata = '0;

    logic [2*HW-1:0] mem [256];
    int wr_cnt = 0;
    int rd_cnt = 0;
    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsb_top u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // Register file model: read data appears the cycle after reg_rd
    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (reg_rd) begin
            reg_rdata <= mem[reg_addr];
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [HW-1:0] d);
        int guard = 0;
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        while (!host_ready && guard < 20) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [HW-1:0] d, output int lat);
        lat = 1;
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        while (!host_rvalid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        d = host_rdata;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [HW-1:0] d;
        int lat, rc;
        check("R1 ready", 32'(host_ready), 32'd1);
        check("R1 strobes", 32'({reg_wr, reg_rd}), 32'd0);
        rc = rd_cnt;
        do_read(8'h00, d, lat);
        check("R1 stage zero", 32'(d), 32'h0);
        check("R6 stage read latency", 32'(lat), 32'd1);
        check("R6 no back-end read", 32'(rd_cnt - rc), 32'd0);
    endtask

    task automatic t_wide_write();
        int wc;
        wc = wr_cnt;
        do_write(8'h00, 16'hABCD);
        check("R2 stage write no back-end", 32'(wr_cnt - wc), 32'd0);
        do_write(8'h44, 16'h1234);
        check("R3 combined word", mem[8'h44], 32'hABCD_1234);
        check("R3 single write", 32'(wr_cnt - wc), 32'd1);
    endtask

    task automatic t_wide_read();
        logic [HW-1:0] d;
        int lat, rc;
        mem[8'h50] = 32'hDEAD_BEEF;
        do_write(8'h00, 16'h7777);
        do_read(8'h50, d, lat);
        check("R4 upper half", 32'(d), 32'hDEAD);
        check("R4 latency", 32'(lat), 32'd3);
        do_read(8'h00, d, lat);
        check("R5 lower parked, pending lost", 32'(d), 32'hBEEF);
        rc = rd_cnt;
        do_read(8'h00, d, lat);
        check("R6 stage unchanged by read", 32'(d), 32'hBEEF);
        check("R6 no back-end read", 32'(rd_cnt - rc), 32'd0);
    endtask

    task automatic t_native();
        logic [HW-1:0] d;
        int lat;
        do_write(8'h00, 16'h5A5A);
        mem[8'h10] = 32'hFFFF_FFFF;
        do_write(8'h10, 16'h0F0F);
        check("R7 zero-extended", mem[8'h10], 32'h0000_0F0F);
        mem[8'h11] = 32'h9999_1357;
        do_read(8'h11, d, lat);
        check("R8 low half", 32'(d), 32'h1357);
        do_read(8'h00, d, lat);
        check("R7 R8 stage kept", 32'(d), 32'h5A5A);
        do_write(8'h48, 16'h0001);
        check("R7 pending upper used later", mem[8'h48], 32'h5A5A_0001);
    endtask

    task automatic t_chan();
        logic [HW-1:0] d;
        int lat;
        do_write(8'h00, 16'hC0DE);
        do_write(8'hF1, 16'h2222);
        check("R9 channel write", mem[8'hF1], 32'h0000_2222);
        mem[8'hF2] = 32'h3333_4444;
        do_read(8'hF2, d, lat);
        check("R9 channel read", 32'(d), 32'h4444);
        do_read(8'h00, d, lat);
        check("R9 stage untouched", 32'(d), 32'hC0DE);
    endtask

    task automatic t_busy();
        logic [HW-1:0] d;
        int wc;
        mem[8'h20] = 32'h1111_2222;
        mem[8'h60] = 32'h0BAD_F00D;
        wc = wr_cnt;
        @(negedge clk);
        host_rd = 1'b1; host_addr = 8'h60;
        @(negedge clk);
        host_rd = 1'b0;
        check("R10 ready low while busy", 32'(host_ready), 32'd0);
        host_wr = 1'b1; host_addr = 8'h20; host_wdata = 16'hEEEE;
        @(negedge clk);
        host_wr = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 strobe ignored", mem[8'h20], 32'h1111_2222);
        check("R10 no extra write", 32'(wr_cnt - wc), 32'd0);
        check("R10 ready restored", 32'(host_ready), 32'd1);
        do_read(8'h00, d, wc);
        check("R5 stage after busy read", 32'(d), 32'hF00D);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wide_write();
        t_wide_read();
        t_native();
        t_chan();
        t_busy();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule